// File: doc/BRIEF.md
# Retentive Interval Timer

This block measures how long an enable condition has been true, in whole seconds. A built-in prescaler divides the system clock into a one-clock tick strobe. On each tick that falls while the run input is high, a decimal-range accumulator (0 to 9999) goes up by one. It stops when it reaches the preset. A done flag reports that the preset has been reached. A timing flag reports that counting is in progress. An enable flag echoes the run input.

Two behaviours are selected by a mode input. In retentive mode, a low run input freezes the accumulator and the done flag. When run returns high, counting resumes from the frozen value. Only the clear input empties the accumulator in this mode. In on-delay mode, a low run input empties the accumulator and drops the flags on the next clock edge. The clear input acts synchronously and overrides everything else.

The control core is a four-state machine:
- IDLE: empty or cleared.
- RUN: counting toward the preset.
- PAUSE: retentive mode, frozen below the preset.
- DONE: the preset has been reached.

The transitions are:
- Any state goes to IDLE on clear.
- Any state goes to RUN or DONE while run is high, depending on whether the next accumulator value reaches the preset.
- Any state goes to IDLE when run is low in on-delay mode.
- RUN goes to PAUSE when run is low in retentive mode.
- IDLE, PAUSE and DONE hold when run is low in retentive mode.

Top module: `rit_timer`

## Requirements
- R1: While rst_n is low, acc_o is 0 and done_o, timing_o and en_o are 0.
- R2: The prescaler raises an internal tick on every TICK_DIV-th rising clock edge after rst_n is released, the first at edge TICK_DIV. On such an edge, with run_i high and acc_o below the effective preset, acc_o increases by exactly one. It never changes by more than one per edge.
- R3: acc_o never increases on an edge where it is already equal to or above the effective preset.
- R4: After an edge with run_i high and clr_i low, done_o is 1 exactly when acc_o is at or above the effective preset, and timing_o equals the inverse of done_o. done_o and timing_o are never high together.
- R5: With retain_i = 1 (retentive mode), an edge with run_i low and clr_i low leaves acc_o and done_o unchanged and sets timing_o to 0. A later high run_i resumes counting from the held acc_o.
- R6: With retain_i = 0 (on-delay mode), an edge with run_i low and clr_i low sets acc_o to 0 and done_o and timing_o to 0.
- R7: After each edge with clr_i low, en_o equals the value run_i had before that edge.
- R8: After an edge with clr_i high, acc_o, done_o, timing_o and en_o are all 0, whatever run_i, retain_i and the tick are in that cycle.
- R9: A preset_i above 9999 acts as 9999, so acc_o never exceeds 9999.
- R10: A preset of 0 with run_i high gives done_o = 1 after the first edge, with acc_o staying 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| run_i | input | 1 | Enable condition; time accumulates while high |
| retain_i | input | 1 | Mode: 1 retentive, 0 on-delay |
| clr_i | input | 1 | Synchronous clear of accumulator and all flags |
| preset_i | input | ACC_W (14) | Target count in seconds, values above 9999 act as 9999 |
| acc_o | output | ACC_W (14) | Accumulated seconds |
| done_o | output | 1 | Accumulator has reached the preset |
| timing_o | output | 1 | Counting in progress |
| en_o | output | 1 | Registered copy of run_i |

## Verification
The clear input and a prescaler tick can land on the same clock edge while run_i is high. That edge asks the accumulator both to step and to empty. The bench provokes this collision by holding clr_i for a full prescaler period during active counting, so one of those edges is certain to carry a tick. It judges the outcome against a cycle-level model, which expects zeros on every output after each such edge. A second overlap comes from a preset lowered below a frozen retentive count: the first edge back in run must land in DONE with no step.

// File: rtl/rit_pkg.sv
package rit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2,
        ST_DONE  = 2'd3
    } rit_state_e;

endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rit_accum.sv
module rit_accum #(
    parameter int ACC_W   = 14,
    parameter int ACC_MAX = 9999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_i,
    input  logic             step_i,
    input  logic [ACC_W-1:0] preset_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             reach_nxt_o
);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(ACC_MAX);

    logic [ACC_W-1:0] pre_eff;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        pre_eff = (preset_i > LIMIT) ? LIMIT : preset_i;
    end

    always_comb begin
        if (zero_i) begin
            acc_d = '0;
        end else if (step_i && (acc_q < pre_eff)) begin
            acc_d = acc_q + 1'b1;
        end else begin
            acc_d = acc_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o       = acc_q;
    assign reach_nxt_o = (acc_d >= pre_eff);
endmodule

// File: rtl/rit_fsm.sv
module rit_fsm
    import rit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic retain_i,
    input  logic clr_i,
    input  logic tick_i,
    input  logic reach_nxt_i,
    output logic zero_o,
    output logic step_o,
    output logic done_o,
    output logic timing_o,
    output logic en_o
);
    rit_state_e st_q;
    rit_state_e st_d;
    logic       en_q;

    assign zero_o = clr_i || (!run_i && !retain_i);
    assign step_o = run_i && tick_i && !clr_i;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = ST_IDLE;
        end else if (run_i) begin
            st_d = reach_nxt_i ? ST_DONE : ST_RUN;
        end else if (!retain_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_RUN:   st_d = ST_PAUSE;
                ST_PAUSE: st_d = ST_PAUSE;
                ST_DONE:  st_d = ST_DONE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            en_q <= 1'b0;
        end else begin
            st_q <= st_d;
            en_q <= clr_i ? 1'b0 : run_i;
        end
    end

    always_comb begin
        done_o   = 1'b0;
        timing_o = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_RUN:   timing_o = 1'b1;
            ST_PAUSE: ;
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
        en_o = en_q;
    end
endmodule

// File: rtl/rit_timer.sv
module rit_timer #(
    parameter int ACC_W    = 14,
    parameter int ACC_MAX  = 9999,
    parameter int TICK_DIV = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             retain_i,
    input  logic             clr_i,
    input  logic [ACC_W-1:0] preset_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             done_o,
    output logic             timing_o,
    output logic             en_o
);
    logic tick;
    logic zero;
    logic step;
    logic reach_nxt;

    rit_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rit_accum #(.ACC_W(ACC_W), .ACC_MAX(ACC_MAX)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .zero_i      (zero),
        .step_i      (step),
        .preset_i    (preset_i),
        .acc_o       (acc_o),
        .reach_nxt_o (reach_nxt)
    );

    rit_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .retain_i    (retain_i),
        .clr_i       (clr_i),
        .tick_i      (tick),
        .reach_nxt_i (reach_nxt),
        .zero_o      (zero),
        .step_o      (step),
        .done_o      (done_o),
        .timing_o    (timing_o),
        .en_o        (en_o)
    );
endmodule

// File: rtl/rit_timer_chk.sv
module rit_timer_chk #(
    parameter int ACC_W   = 14,
    parameter int ACC_MAX = 9999
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             retain_i,
    input logic             clr_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             done_o,
    input logic             timing_o,
    input logic             en_o
);
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timing_o));

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0) && !done_o && !timing_o && !en_o);

    p_en_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (en_o == $past(run_i)));

    p_ondelay_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !run_i && !retain_i) |=> (acc_o == '0) && !done_o && !timing_o);

    p_retain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !run_i && retain_i) |=> $stable(acc_o) && $stable(done_o) && !timing_o);

    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && run_i) |=> ((acc_o == $past(acc_o)) || (acc_o == $past(acc_o) + 1'b1)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o <= ACC_W'(ACC_MAX));
endmodule

bind rit_timer rit_timer_chk #(.ACC_W(ACC_W), .ACC_MAX(ACC_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .retain_i (retain_i),
    .clr_i    (clr_i),
    .acc_o    (acc_o),
    .done_o   (done_o),
    .timing_o (timing_o),
    .en_o     (en_o)
);

// File: tb/rit_timer_tb_top.sv
module rit_timer_tb_top;
    localparam int ACC_W = 14;
    localparam int LIMIT = 9999;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic             retain = 1'b0;
    logic             clr = 1'b0;
    logic [ACC_W-1:0] preset = '0;
    logic [ACC_W-1:0] acc;
    logic             done, timing, en;

    always #5 clk = ~clk;

    rit_timer #(.ACC_W(ACC_W), .ACC_MAX(LIMIT), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .retain_i(retain), .clr_i(clr),
        .preset_i(preset), .acc_o(acc), .done_o(done), .timing_o(timing), .en_o(en)
    );

    typedef struct {
        int    acc;
        bit    done;
        bit    timing;
        bit    en;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 0;

    int m_acc = 0;
    bit m_done = 0, m_timing = 0, m_en = 0;
    int m_k = 0;

    task automatic cyc(input bit r, input bit ret, input bit c, input int pre, input string tag);
        int  pe;
        bit  tk;
        exp_t e;
        run = r; retain = ret; clr = c; preset = ACC_W'(pre);
        m_k++;
        tk = (m_k % DIV) == 0;
        pe = (pre > LIMIT) ? LIMIT : pre;
        if (c) begin
            m_acc = 0; m_done = 0; m_timing = 0; m_en = 0;
        end else begin
            m_en = r;
            if (r) begin
                if (tk && m_acc < pe) m_acc++;
                m_done = (m_acc >= pe);
                m_timing = !m_done;
            end else if (!ret) begin
                m_acc = 0; m_done = 0; m_timing = 0;
            end else begin
                m_timing = 0;
            end
        end
        e.acc = m_acc; e.done = m_done; e.timing = m_timing; e.en = m_en; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (int'(acc) != e.acc || done != e.done || timing != e.timing || en != e.en) begin
                n_bad++;
                $display("FAIL %s: acc=%0d done=%0b timing=%0b en=%0b expected acc=%0d done=%0b timing=%0b en=%0b",
                         e.tag, acc, done, timing, en, e.acc, e.done, e.timing, e.en);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with inputs active
        run = 1; retain = 1; preset = 14'd5;
        repeat (3) @(negedge clk);
        n_vec++;
        if (acc != 0 || done || timing || en) begin
            n_bad++;
            $display("FAIL R1: acc=%0d done=%0b timing=%0b en=%0b expected all 0", acc, done, timing, en);
        end
        rst_n = 1'b1;

        // R2 R4: on-delay count to 3, tick every DIV edges, stop at preset (R3)
        repeat (20) cyc(1, 0, 0, 3, "R2_R3_R4");
        // R6: on-delay drop clears
        repeat (3) cyc(0, 0, 0, 3, "R6");
        // R7: enable echo with toggling run
        cyc(1, 0, 0, 8, "R7"); cyc(0, 0, 0, 8, "R7"); cyc(1, 0, 0, 8, "R7");
        cyc(0, 0, 0, 8, "R7");

        // R5: retentive accumulate, pause, resume
        repeat (10) cyc(1, 1, 0, 5, "R5");
        repeat (11) cyc(0, 1, 0, 5, "R5");
        repeat (14) cyc(1, 1, 0, 5, "R5");
        repeat (5)  cyc(0, 1, 0, 5, "R5");   // done held while paused

        // R8: clear from DONE, then clear during counting across a full tick period
        repeat (2) cyc(0, 1, 1, 5, "R8");
        repeat (9) cyc(1, 1, 0, 6, "R8");
        repeat (DIV + 1) cyc(1, 1, 1, 6, "R8");
        repeat (6) cyc(1, 1, 0, 6, "R8");

        // R5 with preset lowered below the frozen count
        repeat (12) cyc(1, 1, 0, 9, "R5");
        repeat (3)  cyc(0, 1, 0, 9, "R5");
        repeat (3)  cyc(1, 1, 0, 1, "R3_R5");
        cyc(0, 1, 1, 1, "R8");

        // R10: zero preset
        repeat (9) cyc(1, 0, 0, 0, "R10");
        repeat (2) cyc(0, 0, 0, 0, "R10");

        // R9: oversize preset saturates at 9999
        repeat (40020) cyc(1, 1, 0, 16383, "R9");
        repeat (2) cyc(0, 0, 0, 16383, "R6");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule